// File: doc/BRIEF.md
# Sparse Vector Compress and Expand Unit

This block turns dense integer vectors into sparse value/position pairs and back again. It owns three word-wide storage arrays: a dense buffer, a value register and an index register. A host fills and reads these arrays through a simple write port and a read port with one cycle of latency. It then launches one of three operations through a start/opcode command interface, and the engine walks the data at one element per clock.

Gather compresses the dense buffer into its non-zero values and the positions they came from, and reports how many it found. Scatter rebuilds a dense vector from value/index pairs, and every slot that no index addresses holds zero. Mask copies value-register elements into the dense buffer wherever the index register, used as a control vector, is non-zero. The active length of each operation is capped at the strip length `MAXLEN` (128 by default). A sticky error flag reports scatter indices that fall outside the destination.

Top module: `sgs_unit`

## Requirements
- R1: Opcode 0 (gather) reads dense slots 0..len-1 in ascending order and writes each non-zero element to the next free value-register slot, starting at slot 0.
- R2: For each element it gathers, gather writes the element's dense position to the same slot of the index register. Value and index slots at or beyond the final count keep their contents.
- R3: `count` is cleared when a gather is accepted, equals the number of non-zero elements once that gather finishes, and holds through scatter, mask and idle cycles.
- R4: Opcode 1 (scatter) processes pairs j = 0..cnt-1 in order and writes value[j] to dense[index[j]]. When two pairs share an index, the later pair's value remains.
- R5: After a scatter, every dense slot below len that no in-range pair addressed reads zero. Dense slots at or above len are unchanged.
- R6: A scatter pair whose index is at or above len writes nothing and sets `err`. The flag stays set through idle cycles and clears when the next start is accepted.
- R7: Opcode 2 (mask) sets dense[i] = value[i] for each i below len where index[i] is non-zero. Dense slots whose control element is zero keep their contents.
- R8: A `cmd_len` or `cmd_cnt` above `MAXLEN` is treated as `MAXLEN`.
- R9: `busy` is high from the cycle after an accepted start. `done` is high for exactly one cycle when the operation ends, and `busy` is low in that cycle.
- R10: A start request while `busy` is high is ignored. It does not change the running operation and does not cause a second completion.
- R11: A synchronous reset, including one during an operation, brings `busy`, `done`, `count` and `err` to zero.
- R12: Opcode 3 changes no storage and no count, and completes with a single `done` pulse. Storage selects are 0 for the dense buffer, 1 for the value register and 2 for the index register. `host_rdata` shows the addressed entry one cycle after the read address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start request, taken only while idle |
| cmd_op | input | 2 | Opcode: 0 gather, 1 scatter, 2 mask, 3 none |
| cmd_len | input | LENW | Active length (dense length for all operations) |
| cmd_cnt | input | LENW | Number of value/index pairs for scatter |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| count | output | LENW | Number of elements found by the last gather |
| err | output | 1 | Sticky out-of-range scatter index flag |
| host_we | input | 1 | Host write strobe, ignored while busy |
| host_wsel | input | 2 | Storage select for writes |
| host_waddr | input | AW | Host write address |
| host_wdata | input | W | Host write data |
| host_rsel | input | 2 | Storage select for reads |
| host_raddr | input | AW | Host read address |
| host_rdata | output | W | Read data, one cycle after the address |

## Verification
The bench builds the unit with `MAXLEN` set to 16 and 12-bit words. This keeps each full readback of the three arrays short. It also lets a 5-bit length field carry values such as 20 that lie above the strip length, so the clamp on both the length and the pair count is exercised directly. The same small depth means the generated index patterns, which run up to 19, often land out of range or collide. This drives the error flag and the later-pair-wins rule without hand-built data.

// File: rtl/sgs_pkg.sv
package sgs_pkg;

  typedef enum logic [1:0] {
    OP_GATHER  = 2'd0,
    OP_SCATTER = 2'd1,
    OP_MASK    = 2'd2,
    OP_NONE    = 2'd3
  } sgs_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CLR  = 2'd1,
    ST_RUN  = 2'd2
  } sgs_state_e;

  localparam int SEL_DENSE = 0;
  localparam int SEL_VAL   = 1;
  localparam int SEL_IDX   = 2;
  localparam int NUM_MEMS  = 3;

endpackage

// File: rtl/sgs_ram.sv
module sgs_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/sgs_engine.sv
module sgs_engine
  import sgs_pkg::*;
#(
  parameter int MAXLEN = 128,
  parameter int W      = 32,
  parameter int AW     = $clog2(MAXLEN),
  parameter int LENW   = $clog2(MAXLEN + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      op,
  input  logic [LENW-1:0] len,
  input  logic [LENW-1:0] cnt,
  output logic            busy,
  output logic            done,
  output logic [LENW-1:0] count,
  output logic            err,
  output logic [AW-1:0]   raddr,
  input  logic [W-1:0]    dense_rd,
  input  logic [W-1:0]    val_rd,
  input  logic [W-1:0]    idx_rd,
  output logic            dense_we,
  output logic [AW-1:0]   dense_waddr,
  output logic [W-1:0]    dense_wdata,
  output logic            val_we,
  output logic [AW-1:0]   val_waddr,
  output logic [W-1:0]    val_wdata,
  output logic            idx_we,
  output logic [AW-1:0]   idx_waddr,
  output logic [W-1:0]    idx_wdata
);

  localparam logic [LENW-1:0] MAXL = LENW'(MAXLEN);

  sgs_state_e      state_q;
  sgs_op_e         op_q;
  logic [LENW-1:0] len_q, cnt_q, rd_ptr, clr_ptr, p_pos, count_q, n_run;
  logic            p_vld, err_q, done_q;
  logic            issue, finish, in_range;
  logic            g_hit, s_wr, s_bad, m_wr, clr_wr;

  function automatic logic [LENW-1:0] clamp_len(input logic [LENW-1:0] v);
    return (v > MAXL) ? MAXL : v;
  endfunction

  // element count walked in the run phase
  always_comb begin
    case (op_q)
      OP_SCATTER: n_run = cnt_q;
      OP_NONE:    n_run = '0;
      default:    n_run = len_q;
    endcase
  end

  assign issue    = (state_q == ST_RUN) && (rd_ptr < n_run);
  assign finish   = (state_q == ST_RUN) && (rd_ptr == n_run) && !p_vld;
  assign in_range = 32'(idx_rd) < 32'(len_q);

  // second stage: act on read data of the element issued last cycle
  assign g_hit  = p_vld && (op_q == OP_GATHER)  && (dense_rd != '0);
  assign s_wr   = p_vld && (op_q == OP_SCATTER) && in_range;
  assign s_bad  = p_vld && (op_q == OP_SCATTER) && !in_range;
  assign m_wr   = p_vld && (op_q == OP_MASK)    && (idx_rd != '0);
  assign clr_wr = (state_q == ST_CLR) && (clr_ptr < len_q);

  assign raddr       = AW'(rd_ptr);
  assign dense_we    = clr_wr || s_wr || m_wr;
  assign dense_waddr = clr_wr ? AW'(clr_ptr) : (s_wr ? AW'(idx_rd) : AW'(p_pos));
  assign dense_wdata = clr_wr ? '0 : val_rd;
  assign val_we      = g_hit;
  assign val_waddr   = AW'(count_q);
  assign val_wdata   = dense_rd;
  assign idx_we      = g_hit;
  assign idx_waddr   = AW'(count_q);
  assign idx_wdata   = W'(p_pos);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_q    <= OP_GATHER;
      len_q   <= '0;
      cnt_q   <= '0;
      rd_ptr  <= '0;
      clr_ptr <= '0;
      p_vld   <= 1'b0;
      p_pos   <= '0;
      count_q <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (g_hit) count_q <= count_q + 1'b1;
      if (s_bad) err_q <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            op_q    <= sgs_op_e'(op);
            len_q   <= clamp_len(len);
            cnt_q   <= clamp_len(cnt);
            rd_ptr  <= '0;
            clr_ptr <= '0;
            p_vld   <= 1'b0;
            err_q   <= 1'b0;
            if (sgs_op_e'(op) == OP_GATHER) count_q <= '0;
            state_q <= (sgs_op_e'(op) == OP_SCATTER) ? ST_CLR : ST_RUN;
          end
        end
        ST_CLR: begin
          if (clr_ptr == len_q) state_q <= ST_RUN;
          else                  clr_ptr <= clr_ptr + 1'b1;
        end
        ST_RUN: begin
          if (issue) begin
            p_vld  <= 1'b1;
            p_pos  <= rd_ptr;
            rd_ptr <= rd_ptr + 1'b1;
          end else begin
            p_vld <= 1'b0;
          end
          if (finish) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (state_q != ST_IDLE);
  assign done  = done_q;
  assign count = count_q;
  assign err   = err_q;

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R9: the engine is idle whenever it reports completion
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (state_q == ST_IDLE));

  // R10: a start during an operation leaves the latched command alone
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(op_q) && $stable(len_q) && $stable(cnt_q)));

  // R5: run-phase dense writes never land outside the active length
  a_r5_write_in_len: assert property (@(posedge clk) disable iff (rst)
    (dense_we && state_q == ST_RUN) |-> (32'(dense_waddr) < 32'(len_q)));

  // R6: the error flag rises only out of the run phase
  a_r6_err_from_run: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(state_q == ST_RUN));

  // R3: the gather count never passes the strip length
  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    count_q <= MAXL);

endmodule

// File: rtl/sgs_unit.sv
module sgs_unit
  import sgs_pkg::*;
#(
  parameter int MAXLEN = 128,
  parameter int W      = 32,
  parameter int AW     = $clog2(MAXLEN),
  parameter int LENW   = $clog2(MAXLEN + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_start,
  input  logic [1:0]      cmd_op,
  input  logic [LENW-1:0] cmd_len,
  input  logic [LENW-1:0] cmd_cnt,
  output logic            busy,
  output logic            done,
  output logic [LENW-1:0] count,
  output logic            err,
  input  logic            host_we,
  input  logic [1:0]      host_wsel,
  input  logic [AW-1:0]   host_waddr,
  input  logic [W-1:0]    host_wdata,
  input  logic [1:0]      host_rsel,
  input  logic [AW-1:0]   host_raddr,
  output logic [W-1:0]    host_rdata
);

  logic                e_we    [NUM_MEMS];
  logic [AW-1:0]       e_waddr [NUM_MEMS];
  logic [W-1:0]        e_wdata [NUM_MEMS];
  logic                m_we    [NUM_MEMS];
  logic [AW-1:0]       m_waddr [NUM_MEMS];
  logic [W-1:0]        m_wdata [NUM_MEMS];
  logic [W-1:0]        m_rdata [NUM_MEMS];
  logic [AW-1:0]       e_raddr, m_raddr;
  logic [1:0]          rsel_q;

  sgs_engine #(.MAXLEN(MAXLEN), .W(W), .AW(AW), .LENW(LENW)) u_engine (
    .clk         (clk),
    .rst         (rst),
    .start       (cmd_start),
    .op          (cmd_op),
    .len         (cmd_len),
    .cnt         (cmd_cnt),
    .busy        (busy),
    .done        (done),
    .count       (count),
    .err         (err),
    .raddr       (e_raddr),
    .dense_rd    (m_rdata[SEL_DENSE]),
    .val_rd      (m_rdata[SEL_VAL]),
    .idx_rd      (m_rdata[SEL_IDX]),
    .dense_we    (e_we[SEL_DENSE]),
    .dense_waddr (e_waddr[SEL_DENSE]),
    .dense_wdata (e_wdata[SEL_DENSE]),
    .val_we      (e_we[SEL_VAL]),
    .val_waddr   (e_waddr[SEL_VAL]),
    .val_wdata   (e_wdata[SEL_VAL]),
    .idx_we      (e_we[SEL_IDX]),
    .idx_waddr   (e_waddr[SEL_IDX]),
    .idx_wdata   (e_wdata[SEL_IDX])
  );

  // engine owns all ports while busy; host writes are dropped then
  assign m_raddr = busy ? e_raddr : host_raddr;

  for (genvar k = 0; k < NUM_MEMS; k++) begin : g_mem
    assign m_we[k]    = busy ? e_we[k]    : (host_we && (host_wsel == 2'(k)));
    assign m_waddr[k] = busy ? e_waddr[k] : host_waddr;
    assign m_wdata[k] = busy ? e_wdata[k] : host_wdata;

    sgs_ram #(.W(W), .DEPTH(MAXLEN), .AW(AW)) u_ram (
      .clk   (clk),
      .we    (m_we[k]),
      .waddr (m_waddr[k]),
      .wdata (m_wdata[k]),
      .raddr (m_raddr),
      .rdata (m_rdata[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rsel_q <= 2'd0;
    else     rsel_q <= host_rsel;
  end

  always_comb begin
    case (rsel_q)
      2'd0:    host_rdata = m_rdata[SEL_DENSE];
      2'd1:    host_rdata = m_rdata[SEL_VAL];
      2'd2:    host_rdata = m_rdata[SEL_IDX];
      default: host_rdata = '0;
    endcase
  end

  // R11: nothing is running or flagged in the cycle after reset
  a_r11_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && count == '0 && !err));

endmodule

// File: tb/tb_sgs_unit.sv
module tb_sgs_unit;

  localparam int ML    = 16;
  localparam int WW    = 12;
  localparam int AWB   = $clog2(ML);
  localparam int LW    = $clog2(ML + 1);
  localparam int TCLK  = 10;
  localparam int NROW  = 9;
  // op, len, cnt, pattern seed
  localparam int TBL [NROW][4] = '{
    '{0, 16,  0, 1},
    '{0,  9,  0, 2},
    '{0, 20,  0, 3},
    '{1, 16,  8, 4},
    '{1, 10, 12, 5},
    '{1, 16, 20, 6},
    '{2, 16,  0, 7},
    '{2,  5,  0, 8},
    '{3, 16, 16, 9}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_start = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [LW-1:0] cmd_len = '0, cmd_cnt = '0;
  logic busy, done, err;
  logic [LW-1:0] count;
  logic host_we = 1'b0;
  logic [1:0] host_wsel = '0, host_rsel = '0;
  logic [AWB-1:0] host_waddr = '0, host_raddr = '0;
  logic [WW-1:0] host_wdata = '0;
  logic [WW-1:0] host_rdata;

  int nrun = 0, nfail = 0;
  int md [ML], mv [ML], mx [ML];
  int mcount = 0, merr = 0;

  always #(TCLK/2) clk = ~clk;

  sgs_unit #(.MAXLEN(ML), .W(WW)) dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_len(cmd_len), .cmd_cnt(cmd_cnt), .busy(busy), .done(done),
    .count(count), .err(err), .host_we(host_we), .host_wsel(host_wsel),
    .host_waddr(host_waddr), .host_wdata(host_wdata), .host_rsel(host_rsel),
    .host_raddr(host_raddr), .host_rdata(host_rdata)
  );

  task automatic chk(string req, string what, int act, int exp);
    nrun++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  function automatic int clampl(int v);
    return (v > ML) ? ML : v;
  endfunction

  task automatic hw(int sel, int a, int d);
    host_we = 1'b1; host_wsel = 2'(sel); host_waddr = AWB'(a); host_wdata = WW'(d);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic load(int s);
    for (int i = 0; i < ML; i++) begin
      md[i] = ((i + s) % 3 == 0) ? 0 : ((i * 7 + s * 13 + 1) % 4096);
      mv[i] = (i * 5 + s * 11 + 2) % 4096;
      mx[i] = (i * s + s + i) % 20;
      hw(0, i, md[i]);
      hw(1, i, mv[i]);
      hw(2, i, mx[i]);
    end
  endtask

  task automatic model(int op, int len, int cnt);
    int l, p, c;
    l = clampl(len); p = clampl(cnt);
    merr = 0;
    case (op)
      0: begin
        c = 0;
        for (int i = 0; i < l; i++)
          if (md[i] != 0) begin mv[c] = md[i]; mx[c] = i; c++; end
        mcount = c;
      end
      1: begin
        for (int i = 0; i < l; i++) md[i] = 0;
        for (int j = 0; j < p; j++)
          if (mx[j] < l) md[mx[j]] = mv[j]; else merr = 1;
      end
      2: for (int i = 0; i < l; i++) if (mx[i] != 0) md[i] = mv[i];
      default: ;
    endcase
  endtask

  // issue a command and wait for completion; checks R9 timing
  task automatic run(int op, int len, int cnt);
    int t, dc;
    cmd_op = 2'(op); cmd_len = LW'(len); cmd_cnt = LW'(cnt); cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    chk("R9", "busy after start", int'(busy), 1);
    t = 0;
    while (!done && t < 1000) begin @(negedge clk); t++; end
    chk("R9", "busy low during done", int'(busy), 0);
    dc = 0;
    while (done && dc < 5) begin dc++; @(negedge clk); end
    chk("R9", "done width", dc, 1);
    model(op, len, cnt);
  endtask

  task automatic readback(string td, string tv, string tx);
    for (int i = 0; i < ML; i++) begin
      host_rsel = 2'd0; host_raddr = AWB'(i); @(negedge clk);
      chk(td, "dense", int'(host_rdata), md[i]);
      host_rsel = 2'd1; @(negedge clk);
      chk(tv, "value", int'(host_rdata), mv[i]);
      host_rsel = 2'd2; @(negedge clk);
      chk(tx, "index", int'(host_rdata), mx[i]);
    end
  endtask

  initial begin
    string tg;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    chk("R11", "busy", int'(busy), 0);
    chk("R11", "done", int'(done), 0);
    chk("R11", "count", int'(count), 0);
    chk("R11", "err", int'(err), 0);

    for (int r = 0; r < NROW; r++) begin
      load(TBL[r][3]);
      run(TBL[r][0], TBL[r][1], TBL[r][2]);
      case (TBL[r][0])
        0: tg = "R1";
        1: tg = "R4,R5";
        2: tg = "R7";
        default: tg = "R12";
      endcase
      if (TBL[r][1] > ML || (TBL[r][0] == 1 && TBL[r][2] > ML)) tg = {tg, ",R8"};
      chk({tg, ",R3"}, "count", int'(count), mcount);
      chk({tg, ",R6"}, "err", int'(err), merr);
      readback(tg, (TBL[r][0] == 0) ? "R1" : tg, (TBL[r][0] == 0) ? "R2" : tg);
      if (TBL[r][0] == 1 && merr == 1) begin
        repeat (4) @(negedge clk);
        chk("R6", "err sticky while idle", int'(err), 1);
        run(3, 4, 4);
        chk("R6", "err cleared by start", int'(err), 0);
      end
    end

    // R4: duplicate indices, later pair wins
    load(10);
    for (int j = 0; j < 4; j++) begin mx[j] = 3; hw(2, j, 3); end
    run(1, 8, 4);
    chk("R4", "duplicate slot", md[3], mv[3]);
    readback("R4", "R4", "R4");

    // R3: empty gather
    load(11);
    run(0, 0, 0);
    chk("R3", "zero-length count", int'(count), 0);

    // R10: start while busy is ignored
    load(12);
    cmd_op = 2'd0; cmd_len = LW'(16); cmd_start = 1'b1;
    @(negedge clk);
    cmd_op = 2'd1; cmd_len = LW'(4); cmd_cnt = LW'(4);
    @(negedge clk);
    cmd_start = 1'b0;
    begin
      int t, nd;
      t = 0; nd = 0;
      while (t < 200) begin
        if (done) nd++;
        @(negedge clk); t++;
      end
      chk("R10", "done pulses", nd, 1);
    end
    model(0, 16, 0);
    chk("R10", "count of first command", int'(count), mcount);
    readback("R10", "R10", "R10");

    // R11: reset during an operation
    load(13);
    cmd_op = 2'd0; cmd_len = LW'(16); cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11", "busy after mid reset", int'(busy), 0);
    chk("R11", "count after mid reset", int'(count), 0);
    chk("R11", "done after mid reset", int'(done), 0);

    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

endmodule